// File: doc/BRIEF.md
# Switchable Raster Timing Generator

This block produces the output raster for the read side of a frame buffer and for a downstream parallel video transmitter. It runs on whatever pixel clock it is given. It keeps a horizontal pixel counter and a vertical line counter. From their values it derives three qualifiers:

- a frame qualifier that covers the active lines;
- a line qualifier that covers the active pixel columns;
- a data qualifier that marks active pixels.

The counters themselves are also brought out, so a frame buffer can use them as read addresses.

Three raster formats are built in. Each has its own active area and its own total size, which includes the blanking. A static two-bit select picks the format. The block samples the select only when a new frame begins, so a change never produces a torn frame. A synchronous restart pulse returns the raster to its origin, so the output can be realigned when the video source changes. All timing numbers are parameters, and their defaults are the three broadcast formats listed in R5.

Top module: `video_timing_gen`

## Requirements
- R1: `h_count` advances by one on every clock. After reaching the total line length of the current format minus one, it returns to 0.
- R2: `v_count` advances by one only on the clock where `h_count` wraps. After reaching the total line count minus one, it returns to 0. On every other clock it holds its value.
- R3: `frame_valid` is high exactly when `v_count` is below the active line count of the current format. It is high over the whole of each active line, horizontal blanking included.
- R4: `line_valid` is high exactly when `h_count` is below the active pixel count. `data_valid` is high exactly when both `frame_valid` and `line_valid` are high. Active pixels therefore begin at `h_count` = 0 of each active line.
- R5: The select codes map to formats as follows, written as active width × active height inside total width × total height:
  - code 0: 1920×1080 inside 2200×1125;
  - code 1: 720×576 inside 864×625;
  - code 2: 1280×720 inside 1650×750;
  - code 3: treated as code 0.

  `fmt_cur` reports the code of the format in use.
- R6: When `restart` is high at a clock edge, the next cycle shows `h_count` = 0, `v_count` = 0 and `data_valid` high, and the format is loaded from `fmt_sel`. Restart takes priority over the counter wrap.
- R7: A change of `fmt_sel` takes effect only at a frame boundary: the clock after the last pixel of the last line, or after a restart. Within a frame, `fmt_cur` and the limits it selects stay fixed.
- R8: While `rst_n` is low:
  - both counters read 0;
  - `fmt_cur` reads 0;
  - all three qualifiers are low.

  The first cycle after release is the first active pixel of format 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous realign to raster origin |
| fmt_sel | input | 2 | Requested format code |
| frame_valid | output | 1 | High during active lines |
| line_valid | output | 1 | High during active pixel columns |
| data_valid | output | 1 | High on active pixels |
| h_count | output | CNT_W | Pixel position within the line |
| v_count | output | CNT_W | Line position within the frame |
| fmt_cur | output | 2 | Format code currently in use |

## Verification
The bench drives a restart on the very clock where the horizontal and vertical counters sit on their last values. In that cycle the natural frame wrap and the restart both want to reload the counters and the format register. Before asserting the restart, the bench changes `fmt_sel` to a format different from the one in use. A reference model in the bench predicts the outcome for every cycle. The check is that the raster lands at the origin of the new format exactly once, with no extra or missing line and with `fmt_cur` switching in that same cycle. A restart held for two cycles and a mid-frame select change are also covered, to separate the restart path from the boundary path.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
   localparam int NUM_FMT = 3;
   localparam int FMT_W   = 2;

   // unsupported codes fall back to the first format
   function automatic logic [FMT_W-1:0] map_fmt(input logic [FMT_W-1:0] code);
      return (int'(code) < NUM_FMT) ? code : '0;
   endfunction
endpackage

// File: rtl/vtg_counter.sv
module vtg_counter #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         step,
   input  logic [W-1:0] last_val,
   output logic [W-1:0] cnt,
   output logic         at_last
);
   assign at_last = (cnt == last_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (step)
         cnt <= at_last ? '0 : cnt + W'(1);
   end
endmodule

// File: rtl/vtg_fmt_latch.sv
module vtg_fmt_latch
   import vtg_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [FMT_W-1:0] sel,
   output logic [FMT_W-1:0] cur
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cur <= '0;
      else if (load)
         cur <= map_fmt(sel);
   end
endmodule

// File: rtl/vtg_qual.sv
module vtg_qual #(
   parameter int W = 12
) (
   input  logic         rst_n,
   input  logic [W-1:0] h,
   input  logic [W-1:0] v,
   input  logic [W-1:0] h_act,
   input  logic [W-1:0] v_act,
   output logic         fv,
   output logic         lv,
   output logic         dv
);
   logic in_rows, in_cols;

   always_comb begin
      in_rows = (v < v_act);
      in_cols = (h < h_act);
      fv      = rst_n & in_rows;
      lv      = rst_n & in_cols;
      dv      = rst_n & in_rows & in_cols;
   end
endmodule

// File: rtl/video_timing_gen.sv
module video_timing_gen
   import vtg_pkg::*;
#(
   parameter int CNT_W   = 12,
   parameter int H_ACT_A = 1920,
   parameter int H_TOT_A = 2200,
   parameter int V_ACT_A = 1080,
   parameter int V_TOT_A = 1125,
   parameter int H_ACT_B = 720,
   parameter int H_TOT_B = 864,
   parameter int V_ACT_B = 576,
   parameter int V_TOT_B = 625,
   parameter int H_ACT_C = 1280,
   parameter int H_TOT_C = 1650,
   parameter int V_ACT_C = 720,
   parameter int V_TOT_C = 750
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [1:0]       fmt_sel,
   output logic             frame_valid,
   output logic             line_valid,
   output logic             data_valid,
   output logic [CNT_W-1:0] h_count,
   output logic [CNT_W-1:0] v_count,
   output logic [1:0]       fmt_cur
);
   localparam int HA [NUM_FMT] = '{H_ACT_A, H_ACT_B, H_ACT_C};
   localparam int HT [NUM_FMT] = '{H_TOT_A, H_TOT_B, H_TOT_C};
   localparam int VA [NUM_FMT] = '{V_ACT_A, V_ACT_B, V_ACT_C};
   localparam int VT [NUM_FMT] = '{V_TOT_A, V_TOT_B, V_TOT_C};
   localparam longint CNT_SPAN = longint'(1) << CNT_W;

   // elaboration-time sanity of every format
   for (genvar i = 0; i < NUM_FMT; i++) begin : g_fmt_chk
      if (HA[i] < 1 || VA[i] < 1 || HA[i] > HT[i] || VA[i] > VT[i]) begin : g_bad_area
         $error("video_timing_gen: active area of format %0d exceeds its total", i);
      end
      if (longint'(HT[i]) > CNT_SPAN || longint'(VT[i]) > CNT_SPAN) begin : g_bad_width
         $error("video_timing_gen: CNT_W too small for format %0d", i);
      end
   end

   logic [CNT_W-1:0] h_act, v_act, h_last_val, v_last_val;
   logic             h_last, v_last, frame_end, fmt_load;

   always_comb begin
      unique case (fmt_cur)
         2'd1: begin
            h_act = CNT_W'(H_ACT_B);  h_last_val = CNT_W'(H_TOT_B - 1);
            v_act = CNT_W'(V_ACT_B);  v_last_val = CNT_W'(V_TOT_B - 1);
         end
         2'd2: begin
            h_act = CNT_W'(H_ACT_C);  h_last_val = CNT_W'(H_TOT_C - 1);
            v_act = CNT_W'(V_ACT_C);  v_last_val = CNT_W'(V_TOT_C - 1);
         end
         default: begin
            h_act = CNT_W'(H_ACT_A);  h_last_val = CNT_W'(H_TOT_A - 1);
            v_act = CNT_W'(V_ACT_A);  v_last_val = CNT_W'(V_TOT_A - 1);
         end
      endcase
   end

   assign frame_end = h_last & v_last;
   assign fmt_load  = restart | frame_end;

   vtg_fmt_latch u_fmt (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (fmt_load),
      .sel   (fmt_sel),
      .cur   (fmt_cur)
   );

   vtg_counter #(.W(CNT_W)) u_hcnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (restart),
      .step     (1'b1),
      .last_val (h_last_val),
      .cnt      (h_count),
      .at_last  (h_last)
   );

   vtg_counter #(.W(CNT_W)) u_vcnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (restart),
      .step     (h_last),
      .last_val (v_last_val),
      .cnt      (v_count),
      .at_last  (v_last)
   );

   vtg_qual #(.W(CNT_W)) u_qual (
      .rst_n (rst_n),
      .h     (h_count),
      .v     (v_count),
      .h_act (h_act),
      .v_act (v_act),
      .fv    (frame_valid),
      .lv    (line_valid),
      .dv    (data_valid)
   );
endmodule

// File: rtl/vtg_checker.sv
module vtg_checker #(
   parameter int CNT_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             restart,
   input logic             frame_valid,
   input logic             line_valid,
   input logic             data_valid,
   input logic [CNT_W-1:0] h_count,
   input logic [CNT_W-1:0] v_count,
   input logic [1:0]       fmt_cur
);
   assert_h_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (h_count != '0) |-> (h_count == CNT_W'($past(h_count) + CNT_W'(1))));

   assert_v_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (h_count != '0) |-> $stable(v_count));

   assert_fv_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_valid) |-> (h_count == '0 && v_count == '0));

   assert_fv_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(frame_valid) |-> (h_count == '0));

   assert_dv_inside_R4: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid |-> (frame_valid && line_valid));

   assert_restart_origin_R6: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (h_count == '0 && v_count == '0 && data_valid));

   assert_fmt_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fmt_cur != $past(fmt_cur)) |-> (h_count == '0 && v_count == '0));
endmodule

bind video_timing_gen vtg_checker #(.CNT_W(CNT_W)) u_vtg_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .restart     (restart),
   .frame_valid (frame_valid),
   .line_valid  (line_valid),
   .data_valid  (data_valid),
   .h_count     (h_count),
   .v_count     (v_count),
   .fmt_cur     (fmt_cur)
);

// File: tb/video_timing_gen_tb.sv
module video_timing_gen_tb;
   localparam int W = 12;
   localparam int HA [3] = '{8, 5, 6};
   localparam int HT [3] = '{12, 7, 9};
   localparam int VA [3] = '{4, 3, 2};
   localparam int VT [3] = '{6, 5, 4};

   typedef struct packed {
      logic         fv;
      logic         lv;
      logic         dv;
      logic [W-1:0] h;
      logic [W-1:0] v;
      logic [1:0]   f;
   } exp_t;

   logic clk = 0, rst_n = 0, restart = 0;
   logic [1:0] fmt_sel = 2'd2;
   logic frame_valid, line_valid, data_valid;
   logic [W-1:0] h_count, v_count;
   logic [1:0] fmt_cur;

   int checks = 0, fails = 0;
   bit done = 0;
   exp_t q[$];
   int mh, mv, mf;

   always #10 clk = ~clk;

   video_timing_gen #(
      .CNT_W(W),
      .H_ACT_A(HA[0]), .H_TOT_A(HT[0]), .V_ACT_A(VA[0]), .V_TOT_A(VT[0]),
      .H_ACT_B(HA[1]), .H_TOT_B(HT[1]), .V_ACT_B(VA[1]), .V_TOT_B(VT[1]),
      .H_ACT_C(HA[2]), .H_TOT_C(HT[2]), .V_ACT_C(VA[2]), .V_TOT_C(VT[2])
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .restart(restart), .fmt_sel(fmt_sel),
      .frame_valid(frame_valid), .line_valid(line_valid), .data_valid(data_valid),
      .h_count(h_count), .v_count(v_count), .fmt_cur(fmt_cur)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int map(input logic [1:0] s);
      return (s == 2'd3) ? 0 : int'(s);
   endfunction

   function automatic void push_exp();
      exp_t e;
      e.fv = (mv < VA[mf]);
      e.lv = (mh < HA[mf]);
      e.dv = e.fv & e.lv;
      e.h  = W'(mh);
      e.v  = W'(mv);
      e.f  = 2'(mf);
      q.push_back(e);
   endfunction

   // reference model step, R1 R2 R6 R7
   function automatic void model(input logic r, input logic [1:0] s);
      if (r) begin
         mh = 0; mv = 0; mf = map(s);
      end else if (mh == HT[mf] - 1) begin
         mh = 0;
         if (mv == VT[mf] - 1) begin
            mv = 0; mf = map(s);
         end else
            mv++;
      end else
         mh++;
   endfunction

   task automatic step(input logic r, input logic [1:0] s);
      @(negedge clk);
      restart = r;
      fmt_sel = s;
      @(posedge clk);
      model(r, s);
      push_exp();
   endtask

   task automatic run(input int n, input logic [1:0] s);
      for (int i = 0; i < n; i++) step(1'b0, s);
   endtask

   // monitor: compare every cycle against the scoreboard
   always @(negedge clk) begin
      exp_t e;
      if (rst_n && q.size() > 0) begin
         e = q.pop_front();
         chk("R1 h_count", int'(h_count), int'(e.h));
         chk("R2 v_count", int'(v_count), int'(e.v));
         chk("R3 frame_valid", int'(frame_valid), int'(e.fv));
         chk("R4 line_valid", int'(line_valid), int'(e.lv));
         chk("R4 data_valid", int'(data_valid), int'(e.dv));
         chk("R5_R7 fmt_cur", int'(fmt_cur), int'(e.f));
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R8 reset state
      chk("R8 reset h_count", int'(h_count), 0);
      chk("R8 reset v_count", int'(v_count), 0);
      chk("R8 reset fmt_cur", int'(fmt_cur), 0);
      chk("R8 reset qualifiers", int'({frame_valid, line_valid, data_valid}), 0);
      @(posedge clk);
      #2 rst_n = 1;
      mh = 0; mv = 0; mf = 0;
      push_exp();                       // R8 first cycle is active pixel of format 0
      // R7: select 2 held from reset applies only after the first frame
      run(HT[0] * VT[0] + 20, 2'd2);
      // R7: mid-frame change to 1
      run(HT[2] * VT[2] + 30, 2'd1);
      // R6: restart mid-line into format 0
      step(1'b1, 2'd0);
      run(25, 2'd0);
      // R5: code 3 behaves as format 0
      step(1'b1, 2'd3);
      run(HT[0] * VT[0] + 10, 2'd3);
      // R6 with R7: restart on the last pixel of the frame, new select
      while (!(mh == HT[mf] - 1 && mv == VT[mf] - 1)) step(1'b0, 2'd0);
      step(1'b1, 2'd1);
      run(HT[1] * VT[1] + 5, 2'd1);
      // R6: restart held for two cycles
      step(1'b1, 2'd2);
      step(1'b1, 2'd2);
      run(HT[2] * VT[2] + 5, 2'd2);
      @(negedge clk);
      @(negedge clk);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got running expected finished");
         $display("[TB] %0d tests run, %0d failed", checks, fails);
         $finish;
      end
   end
endmodule